// File: doc/BRIEF.md
# Segmented Pipelined Timestamp Counter

This block keeps a wide free-running time count for a measurement system. A prescaler turns the core clock into a periodic tick, and every tick advances the count by one. The count is kept in several equal-width segments instead of one wide adder. The carry from one segment to the next passes through a register, so no carry path is longer than one segment.

Because of the registered carries, segment k+1 takes its step one cycle after segment k wraps. Alignment delay lines hold each lower segment back by the right number of cycles. A final output register then presents all segments from the same logical count. Every downstream consumer therefore reads one coherent timestamp, a fixed number of cycles after the tick that produced it. A valid flag rises once that pipeline has filled after reset.

Top module: `seg_timestamp_ctr`

## Requirements
- R1: While rst_ni is low, asynchronously and without waiting for a clock edge, count_o is zero, valid_o is low, and the prescaler and every segment are cleared.
- R2: With en_i held high, one tick occurs every PRESCALE clock cycles, and each tick adds exactly one to the logical count. The prescaler state never goes beyond PRESCALE-1.
- R3: In a cycle where en_i is low, the prescaler and the lowest segment keep their values, so the count does not advance.
- R4: The count is split into CNT_W/SEG_W segments, with segment 0 holding the least significant bits. A segment changes only in the cycle after a registered carry from the segment below it, and count_o always equals one logical count value, never a mix of segments taken from different counts.
- R5: A tick taken at clock edge n shows up on count_o after edge n+CNT_W/SEG_W.
- R6: valid_o stays low for the first CNT_W/SEG_W rising edges after reset release, goes high after that edge, and stays high until the next reset.
- R7: When the logical count is all ones, the next tick makes it zero. At the output, the count goes from all ones straight to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Count enable; the prescaler and the count hold while low |
| count_o | output | CNT_W | Aligned timestamp |
| valid_o | output | 1 | High once the alignment pipeline has filled after reset |

## Verification
The assertions check several behaviours on every cycle. The prescaler state stays in range. Enable low freezes the prescaler and the lowest segment. An upper segment moves only after a registered carry from below. The output count never steps by more than one per cycle. The valid flag never falls outside reset. Only the bench can show that count_o matches an independent reference count delayed by the exact latency, that ticks fall at the right spacing under irregular enable patterns, that the count wraps correctly across every segment boundary, and that a reset applied mid-run clears everything.

// File: rtl/seg_timestamp_ctr_presc.sv
module seg_timestamp_ctr_presc #(
  parameter int PRESCALE = 6,
  localparam int PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  output logic          tick_o,
  output logic [PW-1:0] presc_o
);
  localparam logic [PW-1:0] TERM = PW'(PRESCALE - 1);

  logic [PW-1:0] presc_q;

  assign tick_o  = en_i && (presc_q == TERM);
  assign presc_o = presc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      presc_q <= '0;
    end else if (en_i) begin
      if (presc_q == TERM) presc_q <= '0;
      else                 presc_q <= presc_q + PW'(1);
    end
  end
endmodule

// File: rtl/seg_timestamp_ctr_seg.sv
module seg_timestamp_ctr_seg #(
  parameter int SEG_W = 14
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  output logic [SEG_W-1:0] seg_o,
  output logic             carry_o
);
  logic [SEG_W-1:0] seg_q;
  logic             carry_q;

  assign seg_o   = seg_q;
  assign carry_o = carry_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seg_q   <= '0;
      carry_q <= 1'b0;
    end else begin
      // carry fires one cycle after this segment rolls over
      carry_q <= inc_i && (&seg_q);
      if (inc_i) seg_q <= seg_q + SEG_W'(1);
    end
  end
endmodule

// File: rtl/seg_timestamp_ctr_align.sv
module seg_timestamp_ctr_align #(
  parameter int W     = 14,
  parameter int DEPTH = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [DEPTH-1:0][W-1:0] pipe_q;

  assign q_o = pipe_q[DEPTH-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pipe_q <= '0;
    end else begin
      pipe_q[0] <= d_i;
      for (int i = 1; i < DEPTH; i++) pipe_q[i] <= pipe_q[i-1];
    end
  end
endmodule

// File: rtl/seg_timestamp_ctr.sv
module seg_timestamp_ctr #(
  parameter int CNT_W    = 42,
  parameter int SEG_W    = 14,
  parameter int PRESCALE = 6,
  localparam int NUM_SEG = CNT_W / SEG_W,
  localparam int PW      = (PRESCALE > 1) ? $clog2(PRESCALE) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  output logic [CNT_W-1:0] count_o,
  output logic             valid_o
);
  logic                     tick;
  logic [PW-1:0]            presc_val;
  logic [NUM_SEG-1:0]       inc;
  logic [NUM_SEG-1:0]       carry;
  logic [CNT_W-1:0]         seg_flat;
  logic [NUM_SEG-1:0]       fill_q;

  seg_timestamp_ctr_presc #(.PRESCALE(PRESCALE)) presc_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en_i),
    .tick_o (tick),
    .presc_o(presc_val)
  );

  for (genvar k = 0; k < NUM_SEG; k++) begin : g_seg
    if (k == 0) begin : g_lo
      assign inc[k] = tick;
    end else begin : g_hi
      assign inc[k] = carry[k-1];
    end

    seg_timestamp_ctr_seg #(.SEG_W(SEG_W)) seg_i (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .inc_i  (inc[k]),
      .seg_o  (seg_flat[k*SEG_W +: SEG_W]),
      .carry_o(carry[k])
    );

    // lower segments lead by one cycle per level; hold them back, plus one output stage
    seg_timestamp_ctr_align #(.W(SEG_W), .DEPTH(NUM_SEG - k)) align_i (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .d_i   (seg_flat[k*SEG_W +: SEG_W]),
      .q_o   (count_o[k*SEG_W +: SEG_W])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) fill_q <= '0;
    else         fill_q <= {fill_q[NUM_SEG-2:0], 1'b1};
  end

  assign valid_o = fill_q[NUM_SEG-1];
endmodule

// File: rtl/seg_timestamp_ctr_chk.sv
module seg_timestamp_ctr_chk #(
  parameter int CNT_W    = 42,
  parameter int SEG_W    = 14,
  parameter int PRESCALE = 6,
  localparam int NUM_SEG = CNT_W / SEG_W,
  localparam int PW      = (PRESCALE > 1) ? $clog2(PRESCALE) : 1
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               en_i,
  input logic [PW-1:0]      presc_val,
  input logic [CNT_W-1:0]   seg_flat,
  input logic [NUM_SEG-1:0] carry,
  input logic [CNT_W-1:0]   count_o,
  input logic               valid_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
  localparam logic [PW-1:0]    TERM = PW'(PRESCALE - 1);

  a_r2_presc_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    presc_val <= TERM);

  a_r3_hold_presc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(presc_val));

  a_r3_hold_seg0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(seg_flat[SEG_W-1:0]));

  a_r6_valid_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> valid_o);

  a_r7_unit_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> (count_o == $past(count_o)) || (count_o == $past(count_o) + ONE));

  for (genvar k = 0; k < NUM_SEG - 1; k++) begin : g_carry
    a_r4_carry_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !carry[k] |=> $stable(seg_flat[(k+1)*SEG_W +: SEG_W]));
  end
endmodule

bind seg_timestamp_ctr seg_timestamp_ctr_chk #(
  .CNT_W(CNT_W), .SEG_W(SEG_W), .PRESCALE(PRESCALE)
) chk_i (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .en_i     (en_i),
  .presc_val(presc_val),
  .seg_flat (seg_flat),
  .carry    (carry),
  .count_o  (count_o),
  .valid_o  (valid_o)
);

// File: tb/seg_timestamp_ctr_tb_top.sv
module seg_timestamp_ctr_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int TB_W       = 12;
  localparam int TB_SEG     = 4;
  localparam int TB_PRE     = 2;
  localparam int NSEG       = TB_W / TB_SEG;
  localparam logic [TB_W-1:0] ALL1 = '1;

  logic            clk = 1'b0;
  logic            rst_ni = 1'b0;
  logic            en_i = 1'b0;
  logic [TB_W-1:0] count_o;
  logic            valid_o;

  int n_chk = 0;
  int n_bad = 0;
  int presc_m;
  int edges;
  logic [TB_W-1:0] cnt_m;
  logic [TB_W-1:0] prev_exp;
  logic [TB_W-1:0] exp_q[$];
  logic [7:0] lfsr = 8'hA5;

  seg_timestamp_ctr #(.CNT_W(TB_W), .SEG_W(TB_SEG), .PRESCALE(TB_PRE)) dut_i (
    .clk_i  (clk),
    .rst_ni (rst_ni),
    .en_i   (en_i),
    .count_o(count_o),
    .valid_o(valid_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input longint act, input longint exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  task automatic model_reset();
    presc_m  = 0;
    cnt_m    = '0;
    prev_exp = '0;
    edges    = 0;
    exp_q.delete();
    for (int i = 0; i < NSEG; i++) exp_q.push_back('0);
  endtask

  // drive en for one edge, then compare at the following falling edge
  task automatic step(input bit en, input string tag);
    logic [TB_W-1:0] e;
    en_i = en;
    @(posedge clk);
    @(negedge clk);
    if (en) begin
      if (presc_m == TB_PRE - 1) begin
        presc_m = 0;
        cnt_m   = cnt_m + 1'b1;
      end else begin
        presc_m++;
      end
    end
    exp_q.push_back(cnt_m);
    e = exp_q.pop_front();
    edges++;
    if (e == '0 && prev_exp == ALL1) check("R7", count_o, e);
    else                             check(tag, count_o, e);
    check("R6", valid_o, (edges >= NSEG));
    prev_exp = e;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  initial begin
    model_reset();
    #(CLK_PERIOD * 2 + 2);
    check("R1", count_o, 0);
    check("R1", valid_o, 0);
    @(negedge clk);
    rst_ni = 1'b1;

    for (int i = 0; i < 8; i++)  step(1'b1, "R6");
    for (int i = 0; i < 30; i++) step(1'b1, "R5");
    for (int i = 0; i < 200; i++) begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      step(lfsr[0], "R3");
    end
    for (int i = 0; i < 10; i++)  step(1'b0, "R3");
    for (int i = 0; i < 100; i++) step(1'b1, "R2");
    // run past a full wrap so every segment carry and the top rollover occur
    for (int i = 0; i < 8500; i++) step(1'b1, "R4");

    // asynchronous reset in the middle of a cycle
    @(negedge clk);
    #2 rst_ni = 1'b0;
    #1;
    check("R1", count_o, 0);
    check("R1", valid_o, 0);
    @(negedge clk);
    check("R1", count_o, 0);
    rst_ni = 1'b1;
    model_reset();
    for (int i = 0; i < 20; i++) step(1'b1, "R6");
    for (int i = 0; i < 40; i++) step(1'b1, "R2");

    summary();
  end
endmodule